// File: doc/BRIEF.md
# Reset-Time Configuration Strap Latch

This block captures the levels of configuration straps, which share their pins with output signals, once, when the device leaves reset. It then holds that configuration for the rest of the device until the next hardware reset. A hardware reset is any loss of the power-good indication or any assertion of the active-low reset pin. The straps carry a two-bit interface mode and a five-bit management address. The strap inputs and the release condition pass through a synchronizer, and capture happens on the first clock at which the synchronized release is seen.

The captured mode is decoded into one-hot interface selects, plus a pin-remap flag for the single-clock MII mode. The mode and address are readable through a read-only status word. Each incoming management frame address is compared against the latched address to produce a registered response-enable. While reset is active, and until one clock after capture, the output drivers on the shared pins stay disabled, so the device never fights the external resistors during sampling. A soft reset from the control register never re-samples the straps and leaves the captured configuration unchanged.

Top module: `cfg_strap_latch`

## Requirements
- R1: While `por_ok` is low or `rst_pin_n` is low, `strap_status`, `if_sel`, `pin_remap`, `pad_oe` and `resp_en` are all zero.
- R2: After both `por_ok` and `rst_pin_n` are high, the strap values sampled at the first rising clock edge are captured at the third rising edge. Changes to the strap inputs after the first edge do not alter what is captured.
- R3: `pad_oe` is low during reset and stays low through the capture edge. It rises at the next rising edge if the captured mode is valid.
- R4: `soft_rst` and any strap change after capture leave `strap_status`, `if_sel`, `pin_remap` and `pad_oe` unchanged.
- R5: Mode decode drives `if_sel` as follows. 01 (MII, 25 MHz crystal) gives bit 0. 10 (RMII, 50 MHz reference input) gives bit 1. 11 (single-clock MII, 25 MHz crystal) gives bit 2. Before capture, `if_sel` is 000.
- R6: `pin_remap` is high only when mode 11 is captured. It means the transmit clock and transmit error pins take other duties, and the receive clock pin drives the single MII clock.
- R7: The bit fields of `strap_status` are: [7:3] the latched address, [2] the invalid-mode flag, [1:0] the latched mode. The word is all zero before capture.
- R8: A captured mode of 00 sets `strap_status[2]`, keeps `if_sel` at 000, and keeps `pad_oe` low.
- R9: `resp_en` is high for the cycle after `mf_valid` is high with `mf_addr` equal to the latched address. It requires that capture had already happened at that edge and that `soft_rst` was low in that cycle.
- R10: With `ADDR_W` = 4, `strap_status[7]` is zero, and `mf_addr[4]` is ignored by the match.
- R11: Any later hardware reset clears the captured state, and the following release captures the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_ok | input | 1 | Power-good indication, high when all supplies are good |
| rst_pin_n | input | 1 | Active-low reset pin |
| soft_rst | input | 1 | Soft reset from the control register bit |
| strap_mode_i | input | 2 | Mode strap levels |
| strap_addr_i | input | 5 | Management address strap levels |
| mf_valid | input | 1 | Management frame address valid |
| mf_addr | input | 5 | Address field of the management frame |
| resp_en | output | 1 | Frame response enable, registered |
| pad_oe | output | 1 | Output-driver enable for the shared strap pins |
| if_sel | output | 3 | One-hot interface select: [0] MII, [1] RMII, [2] single-clock MII |
| pin_remap | output | 1 | Single-clock MII pin reassignment active |
| strap_status | output | 8 | Read-only status: {address, invalid, mode} |

## Verification
Two functions can fall in the same cycle. The capture edge can coincide with a soft reset, and it can coincide with a management frame. The bench holds `soft_rst` high and presents a matching frame continuously across a release. It then expects the capture to proceed regardless of the soft reset, and expects no response until capture has happened and the soft reset is gone. A behavioural model tracks the release count and a two-deep history of strap samples. On every clock it is compared with both a five-bit and a four-bit address instance, which also covers a strap change inside the synchronizer window.

// File: rtl/cfg_strap_pkg.sv
`timescale 1ns/1ps
package cfg_strap_pkg;

  localparam int FULL_AW  = 5;
  localparam int MODE_W   = 2;
  localparam int IF_SEL_W = 3;
  localparam int STAT_W   = FULL_AW + 1 + MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_RSVD  = 2'b00,
    MODE_MII   = 2'b01,
    MODE_RMII  = 2'b10,
    MODE_SCMII = 2'b11
  } strap_mode_e;

  function automatic logic [IF_SEL_W-1:0] if_decode(input strap_mode_e m);
    logic [IF_SEL_W-1:0] sel;
    case (m)
      MODE_MII:   sel = 3'b001;
      MODE_RMII:  sel = 3'b010;
      MODE_SCMII: sel = 3'b100;
      default:    sel = 3'b000;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/strap_sync.sv
`timescale 1ns/1ps
module strap_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_chain
      always_comb begin
        stage_d[gi] = stage_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture
  import cfg_strap_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rel_s,
  input  logic [MODE_W-1:0]  mode_s,
  input  logic [FULL_AW-1:0] addr_s,
  output logic               done_q,
  output strap_mode_e        mode_q,
  output logic [FULL_AW-1:0] addr_q,
  output logic               mode_bad,
  output logic               oe_q
);

  logic [FULL_AW-1:0] addr_keep;

  generate
    if (ADDR_W < FULL_AW) begin : g_narrow
      assign addr_keep = {{(FULL_AW-ADDR_W){1'b0}}, addr_s[ADDR_W-1:0]};
      assert_narrow_top_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        addr_q[FULL_AW-1] == 1'b0);
    end else begin : g_full
      assign addr_keep = addr_s;
    end
  endgenerate

  logic               cap_en;
  logic               done_d;
  logic               oe_d;
  strap_mode_e        mode_d;
  logic [FULL_AW-1:0] addr_d;

  always_comb begin
    cap_en = rel_s & ~done_q;
    done_d = done_q | rel_s;
    mode_d = cap_en ? strap_mode_e'(mode_s) : mode_q;
    addr_d = cap_en ? addr_keep : addr_q;
    oe_d   = done_q & (mode_q != MODE_RSVD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      mode_q <= MODE_RSVD;
      addr_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      oe_q   <= oe_d;
      if (cap_en) begin
        mode_q <= mode_d;
        addr_q <= addr_d;
      end
    end
  end

  assign mode_bad = done_q & (mode_q == MODE_RSVD);

  // R4: once captured, the configuration never moves until a hardware reset
  assert_status_stable_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> ($stable(mode_q) && $stable(addr_q)));

  // R3: the driver enable only rises a clock after capture had completed
  assert_oe_after_capture_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(done_q));

  // R8: an invalid captured mode keeps the drivers off
  assert_invalid_no_oe_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad |-> !oe_q);

endmodule

// File: rtl/mgmt_addr_match.sv
`timescale 1ns/1ps
module mgmt_addr_match
  import cfg_strap_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done,
  input  logic [FULL_AW-1:0] addr_q,
  input  logic               mf_valid,
  input  logic [FULL_AW-1:0] mf_addr,
  input  logic               soft_rst,
  output logic               resp_en
);

  logic hit;
  logic resp_d;

  always_comb begin
    hit    = (mf_addr[ADDR_W-1:0] == addr_q[ADDR_W-1:0]);
    resp_d = mf_valid & done & hit & ~soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_en <= 1'b0;
    else        resp_en <= resp_d;
  end

  // R9: a response follows only a valid frame presented in the prior cycle
  assert_resp_follows_frame_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    resp_en |-> ($past(mf_valid) && !$past(soft_rst)));

endmodule

// File: rtl/cfg_strap_latch.sv
`timescale 1ns/1ps
module cfg_strap_latch
  import cfg_strap_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         por_ok,
  input  logic         rst_pin_n,
  input  logic         soft_rst,
  input  logic [1:0]   strap_mode_i,
  input  logic [4:0]   strap_addr_i,
  input  logic         mf_valid,
  input  logic [4:0]   mf_addr,
  output logic         resp_en,
  output logic         pad_oe,
  output logic [2:0]   if_sel,
  output logic         pin_remap,
  output logic [7:0]   strap_status
);

  localparam int SYNC_W = 1 + MODE_W + FULL_AW;

  logic              rst_n;
  logic [SYNC_W-1:0] sync_d;
  logic [SYNC_W-1:0] sync_q;

  assign rst_n  = por_ok & rst_pin_n;
  assign sync_d = {1'b1, strap_mode_i, strap_addr_i};

  strap_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_d),
    .q     (sync_q)
  );

  logic               done_q;
  strap_mode_e        mode_q;
  logic [FULL_AW-1:0] addr_q;
  logic               mode_bad;

  strap_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel_s    (sync_q[SYNC_W-1]),
    .mode_s   (sync_q[FULL_AW +: MODE_W]),
    .addr_s   (sync_q[FULL_AW-1:0]),
    .done_q   (done_q),
    .mode_q   (mode_q),
    .addr_q   (addr_q),
    .mode_bad (mode_bad),
    .oe_q     (pad_oe)
  );

  mgmt_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done_q),
    .addr_q   (addr_q),
    .mf_valid (mf_valid),
    .mf_addr  (mf_addr),
    .soft_rst (soft_rst),
    .resp_en  (resp_en)
  );

  always_comb begin
    if_sel       = done_q ? if_decode(mode_q) : 3'b000;
    pin_remap    = if_sel[2];
    strap_status = {addr_q, mode_bad, mode_q};
  end

  // R5: at most one interface is selected
  assert_ifsel_onehot_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(if_sel));

  // R6: pin reassignment only with single-clock MII in the status word
  assert_remap_scmii_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    pin_remap |-> (strap_status[1:0] == 2'b11));

  // R3: drivers stay off while the status still shows nothing captured
  assert_oe_off_uncaptured_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (if_sel == 3'b000) |-> !pad_oe);

endmodule

// File: tb/tb_cfg_strap_latch.sv
`timescale 1ns/1ps
module tb_cfg_strap_latch;

  logic       clk = 1'b0;
  logic       por_ok, rst_pin_n, soft_rst, mf_valid;
  logic [1:0] strap_mode;
  logic [4:0] strap_addr, mf_addr;

  logic       resp_en, pad_oe, pin_remap;
  logic [2:0] if_sel;
  logic [7:0] strap_status;
  logic       resp_en4, pad_oe4, pin_remap4;
  logic [2:0] if_sel4;
  logic [7:0] strap_status4;

  always #2 clk = ~clk;  // 250 MHz

  cfg_strap_latch #(.ADDR_W(5)) dut (
    .clk(clk), .por_ok(por_ok), .rst_pin_n(rst_pin_n), .soft_rst(soft_rst),
    .strap_mode_i(strap_mode), .strap_addr_i(strap_addr),
    .mf_valid(mf_valid), .mf_addr(mf_addr),
    .resp_en(resp_en), .pad_oe(pad_oe), .if_sel(if_sel),
    .pin_remap(pin_remap), .strap_status(strap_status)
  );

  cfg_strap_latch #(.ADDR_W(4)) dut_n4 (
    .clk(clk), .por_ok(por_ok), .rst_pin_n(rst_pin_n), .soft_rst(soft_rst),
    .strap_mode_i(strap_mode), .strap_addr_i(strap_addr),
    .mf_valid(mf_valid), .mf_addr(mf_addr),
    .resp_en(resp_en4), .pad_oe(pad_oe4), .if_sel(if_sel4),
    .pin_remap(pin_remap4), .strap_status(strap_status4)
  );

  // behavioural reference
  wire  rel_n = por_ok & rst_pin_n;
  int   rel_cnt;
  bit   m_done, m_oe, m_resp, m_resp4;
  bit [1:0] m_mode;
  bit [4:0] m_addr;
  bit [6:0] hist1, hist2;  // {mode, addr} sampled one and two edges ago

  always @(posedge clk or negedge rel_n) begin
    if (!rel_n) begin
      rel_cnt = 0; m_done = 0; m_oe = 0; m_resp = 0; m_resp4 = 0;
      m_mode = 0; m_addr = 0; hist1 = 0; hist2 = 0;
    end else begin
      m_resp  = mf_valid && m_done && !soft_rst && (mf_addr == m_addr);
      m_resp4 = mf_valid && m_done && !soft_rst && (mf_addr[3:0] == m_addr[3:0]);
      m_oe    = m_done && (m_mode != 2'b00);
      if (rel_cnt == 2 && !m_done) begin
        m_mode = hist2[6:5];
        m_addr = hist2[4:0];
        m_done = 1;
      end
      hist2 = hist1;
      hist1 = {strap_mode, strap_addr};
      if (rel_cnt < 3) rel_cnt = rel_cnt + 1;
    end
  end

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 0;
  string phase = "R1";

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [2:0] e_sel;
    logic [4:0] a4;
    case (m_mode)
      2'b01:   e_sel = 3'b001;
      2'b10:   e_sel = 3'b010;
      2'b11:   e_sel = 3'b100;
      default: e_sel = 3'b000;
    endcase
    if (!m_done) e_sel = 3'b000;
    a4 = {1'b0, m_addr[3:0]};
    chk("status R7", strap_status,
        m_done ? {m_addr, (m_mode == 2'b00), m_mode} : 8'h00);
    chk("if_sel R5", {5'b0, if_sel}, {5'b0, e_sel});
    chk("pin_remap R6", {7'b0, pin_remap}, {7'b0, (m_done && m_mode == 2'b11)});
    chk("pad_oe R3", {7'b0, pad_oe}, {7'b0, m_oe});
    chk("resp_en R9", {7'b0, resp_en}, {7'b0, m_resp});
    chk("status4 R10", strap_status4,
        m_done ? {a4, (m_mode == 2'b00), m_mode} : 8'h00);
    chk("resp_en4 R10", {7'b0, resp_en4}, {7'b0, m_resp4});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      compare_all();
      @(negedge clk);
    end
  endtask

  task automatic frame(input logic [4:0] a);
    mf_valid = 1; mf_addr = a; tick(1);
    mf_valid = 0; tick(1);
  endtask

  initial begin
    por_ok = 0; rst_pin_n = 1; soft_rst = 0; mf_valid = 0; mf_addr = 0;
    strap_mode = 2'b01; strap_addr = 5'h15;
    @(negedge clk);
    phase = "R1"; tick(3);
    por_ok = 1; rst_pin_n = 0; tick(3);

    // R2: release, then change straps after the first sampling edge
    phase = "R2"; rst_pin_n = 1; tick(1);
    strap_mode = 2'b10; strap_addr = 5'h0A; tick(6);

    // R9/R10 address matching on the latched 0x15
    phase = "R9"; frame(5'h15); frame(5'h14);
    phase = "R10"; frame(5'h05);

    // R4: soft reset and strap change do nothing; soft reset blocks response
    phase = "R4"; soft_rst = 1; strap_mode = 2'b11; strap_addr = 5'h02;
    mf_valid = 1; mf_addr = 5'h15; tick(1);
    soft_rst = 0; mf_valid = 0; tick(3);

    // R11/R6: pin reset recaptures single-clock MII
    phase = "R11"; rst_pin_n = 0; tick(2);
    rst_pin_n = 1; tick(6);
    phase = "R6"; frame(5'h02);

    // R5: power-good loss, RMII, full-range address
    phase = "R5"; por_ok = 0; strap_mode = 2'b10; strap_addr = 5'h1F; tick(2);
    por_ok = 1; tick(6); frame(5'h1F); frame(5'h0F);

    // R8: reserved mode
    phase = "R8"; rst_pin_n = 0; strap_mode = 2'b00; strap_addr = 5'h07; tick(2);
    rst_pin_n = 1; tick(7);

    // capture coinciding with soft reset and with a live frame
    phase = "R4/R9"; rst_pin_n = 0; strap_mode = 2'b01; strap_addr = 5'h0C; tick(2);
    soft_rst = 1; mf_valid = 1; mf_addr = 5'h0C; rst_pin_n = 1; tick(6);
    soft_rst = 0; tick(2);
    rst_pin_n = 0; tick(1);
    phase = "R2/R9"; rst_pin_n = 1; tick(6);
    mf_valid = 0; tick(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule